// File: doc/BRIEF.md
# Chroma Edge Sharpener

This block sharpens horizontal colour edges in a pair of 8-bit chrominance streams (U and V) that arrive together under a single pixel-valid strobe. Each stream is smoothed with a short lowpass kernel. First and second horizontal differences are taken on the smoothed data. A pixel is marked active when the combined slope magnitude of both components is larger than a programmable threshold. An edge centre is placed where the slope-oriented curvature of the two components changes from positive to non-positive. Around each centre, the run of active pixels is clipped to a programmable reach on each side. Inside that region the gradual ramp is replaced by a hard step: pixels before the centre take the colour at the region's first pixel, and pixels at or after the centre take the colour at its last pixel.

The block sits in a video datapath. Software sets the threshold and the reach through plain register inputs, and the stream passes through with a fixed latency counted in accepted pixels. Cycles without a valid pixel freeze the whole pipeline, so the stream can be gapped freely.

Top module: `chroma_edge_sharpener`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `out_u` and `out_v` are 0. All history is cleared, so samples before the first accepted pixel count as 0.
- R2: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. The output accepted-pixel latency is LAT = D+1, where D = max(4+MAXW, 3+2·MAXW) (LAT is 10 for MAXW=3). The output that follows the k-th accepted pixel (counting from 0) carries pixel k−LAT.
- R3: The smoothed sample is f[i] = (x[i−1] + 2·x[i] + x[i+1] + 2) >> 2. This is computed separately for U and for V.
- R4: The first difference is g[i] = f[i+1] − f[i−1] and the second difference is h[i] = f[i+1] − 2·f[i] + f[i−1], both signed. Pixel i is active when |gU[i]| + |gV[i]| > `thresh` (strictly greater).
- R5: With z[i] = sgn(gU[i])·hU[i] + sgn(gV[i])·hV[i], pixel c is a centre when pixels c and c−1 are both active, z[c−1] > 0 and z[c] ≤ 0.
- R6: With W = min(`width`, MAXW), a centre's region runs from c−L to c+Rt. L is the number of consecutive active pixels directly left of c, capped at W. Rt is the same count to the right of c, also capped at W.
- R7: A pixel n inside a region takes the U and V values of the region's first pixel if n < c, and of its last pixel if n ≥ c. When several regions cover n, the nearest centre wins, and on a tie the centre to the left of n wins.
- R8: A pixel covered by no region is output unchanged: its raw U and V values appear after the R2 latency.
- R9: In a cycle with `in_valid` low, no state advances. The next cycle shows `out_valid` low with `out_u` and `out_v` unchanged, and gaps do not alter any later output value.
- R10: A `thresh` of at least 2·(2^8−1) = 510 makes no pixel active, so the output equals the input delayed by LAT pixels.
- R11: A `width` of 0 gives every region a single pixel, so the output equals the delayed input for any threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel strobe; low cycles stall the pipeline |
| in_u | input | 8 | U chrominance sample |
| in_v | input | 8 | V chrominance sample |
| thresh | input | 10 | Slope threshold for the active test |
| width | input | 2 | Region reach on each side of a centre (capped at MAXW) |
| out_valid | output | 1 | Output pixel strobe |
| out_u | output | 8 | Sharpened U sample |
| out_v | output | 8 | Sharpened V sample |

## Verification
A wrong smoothing, difference or activity bit moves a region edge or a centre. This shows up exactly LAT accepted pixels later as a wrong level on pixels next to a colour transition, while flat areas stay correct, so the bench compares every output pixel against an arithmetic model. A stall leak, where state shifts on a gap cycle, misaligns every later pixel of the stream and breaks the strobe rule on the very next cycle. A wrong priority between overlapping regions only shows where two centres lie within reach of each other, which the noisy pattern provokes.

// File: rtl/chroma_sharp_pkg.sv
// Shared constants and helpers for the chroma edge sharpener.
// Assumes: the helpers are evaluated at elaboration time only.
package chroma_sharp_pkg;

    localparam int CS_DATA_W    = 8;   // chroma sample width
    localparam int CS_MAX_REACH = 3;   // largest per-side region reach

    // Pixel delay between the newest accepted sample and the decided pixel.
    function automatic int cs_decide_delay(input int maxw);
        return ((4 + maxw) > (3 + 2 * maxw)) ? (4 + maxw) : (3 + 2 * maxw);
    endfunction

    // Width of a field able to hold 0..maxw.
    function automatic int cs_reach_bits(input int maxw);
        return (maxw < 2) ? 1 : $clog2(maxw + 1);
    endfunction

endpackage

// File: rtl/cs_feature.sv
// Per-component front end: raw sample history, [1 2 1]/4 smoothing and
// first/second differences of the smoothed stream.
// Assumes: adv is high exactly when a new sample is accepted. The difference
// outputs describe pixel (newest - 2) and depend only on the held history.
module cs_feature #(
    parameter int DW    = chroma_sharp_pkg::CS_DATA_W,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    input  logic [DW-1:0]              din,
    output logic [DEPTH-1:0][DW-1:0]   taps,
    output logic signed [DW:0]         d1,
    output logic signed [DW+1:0]       d2
);
    localparam int SW = DW + 2;

    logic [DEPTH-1:0][DW-1:0] hist;
    logic [SW-1:0]            sum_a, sum_b, sum_c;
    logic [DW-1:0]            f_a, f_b, f_c;

    // Shift the raw history by one pixel on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (adv) begin
            hist <= {hist[DEPTH-2:0], din};
        end
    end

    // Smooth three consecutive positions with rounding.
    always_comb begin
        sum_a = SW'(hist[0]) + {1'b0, hist[1], 1'b0} + SW'(hist[2]) + SW'(2);
        sum_b = SW'(hist[1]) + {1'b0, hist[2], 1'b0} + SW'(hist[3]) + SW'(2);
        sum_c = SW'(hist[2]) + {1'b0, hist[3], 1'b0} + SW'(hist[4]) + SW'(2);
        f_a   = sum_a[SW-1:2];
        f_b   = sum_b[SW-1:2];
        f_c   = sum_c[SW-1:2];
    end

    // Central first and second differences around the middle position.
    always_comb begin
        d1 = $signed({1'b0, f_a}) - $signed({1'b0, f_c});
        d2 = $signed({2'b00, f_a}) - $signed({1'b0, f_b, 1'b0}) + $signed({2'b00, f_c});
    end

    assign taps = hist;

endmodule

// File: rtl/cs_detect.sv
// Combines both components into an activity flag and a slope-oriented
// curvature per pixel, then finds centres where that curvature turns from
// positive to non-positive across two active pixels.
// Assumes: inputs describe pixel (newest - 2). act_win[i] holds pixel
// (newest - 3 - i) and ctr_win[i] holds pixel (newest - 4 - i).
module cs_detect #(
    parameter int DW   = chroma_sharp_pkg::CS_DATA_W,
    parameter int TW   = DW + 2,
    parameter int FLEN = 13,
    parameter int CLEN = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic signed [DW:0]      d1u,
    input  logic signed [DW+1:0]    d2u,
    input  logic signed [DW:0]      d1v,
    input  logic signed [DW+1:0]    d2v,
    input  logic [TW-1:0]           thresh,
    output logic [FLEN-1:0]         act_win,
    output logic [CLEN-1:0]         ctr_win
);
    localparam int ZW = DW + 3;

    logic [DW:0]           mag_u, mag_v;
    logic [TW-1:0]         mag_sum;
    logic                  act_new, ctr_new;
    logic signed [ZW-1:0]  term_u, term_v, z_new, z_q0, z_q1;

    // Slope magnitude sum against the threshold.
    always_comb begin
        mag_u   = d1u[DW] ? $unsigned(-d1u) : $unsigned(d1u);
        mag_v   = d1v[DW] ? $unsigned(-d1v) : $unsigned(d1v);
        mag_sum = TW'(mag_u) + TW'(mag_v);
        act_new = (mag_sum > thresh);
    end

    // Curvature oriented by the slope sign of each component.
    always_comb begin
        if (d1u == '0)    term_u = '0;
        else if (d1u[DW]) term_u = -ZW'(d2u);
        else              term_u = ZW'(d2u);
        if (d1v == '0)    term_v = '0;
        else if (d1v[DW]) term_v = -ZW'(d2v);
        else              term_v = ZW'(d2v);
        z_new = term_u + term_v;
    end

    // Centre test on the two most recently stored pixels.
    always_comb begin
        ctr_new = act_win[0] && act_win[1] && (z_q1 > 0) && (z_q0 <= 0);
    end

    // Store activity, curvature and centre flags, one pixel per accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_win <= '0;
            ctr_win <= '0;
            z_q0    <= '0;
            z_q1    <= '0;
        end else if (adv) begin
            act_win <= {act_win[FLEN-2:0], act_new};
            ctr_win <= {ctr_win[CLEN-2:0], ctr_new};
            z_q0    <= z_new;
            z_q1    <= z_q0;
        end
    end

endmodule

// File: rtl/cs_select.sv
// Decides the output of pixel n = newest - D. It scans candidate centres at
// offsets 0, -1, +1, -2, +2, ... and takes the first whose clipped region
// covers n. It then picks the region's first or last raw value, or passes
// n through.
// Assumes: window indices follow the fixed offsets set by cs_feature and
// cs_detect; D is large enough that every index stays inside its window.
module cs_select #(
    parameter int DW   = chroma_sharp_pkg::CS_DATA_W,
    parameter int MAXW = chroma_sharp_pkg::CS_MAX_REACH,
    parameter int D    = 9,
    parameter int RLEN = 16,
    parameter int FLEN = 13,
    parameter int CLEN = 9,
    parameter int WW   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic [WW-1:0]            width,
    input  logic [RLEN-1:0][DW-1:0]  raw_u,
    input  logic [RLEN-1:0][DW-1:0]  raw_v,
    input  logic [FLEN-1:0]          act_win,
    input  logic [CLEN-1:0]          ctr_win,
    output logic                     out_valid,
    output logic [DW-1:0]            out_u,
    output logic [DW-1:0]            out_v
);
    localparam int NCAND = 2 * MAXW + 1;

    int             wlim;
    logic           hit;
    logic [DW-1:0]  sel_u, sel_v;

    // Effective reach: the programmed width clipped to the window size.
    always_comb begin
        wlim = (int'(width) > MAXW) ? MAXW : int'(width);
    end

    // Nearest-centre search with left preference on ties.
    always_comb begin
        hit   = 1'b0;
        sel_u = raw_u[D];
        sel_v = raw_v[D];
        for (int k = 0; k < NCAND; k++) begin
            int   d;
            int   lcnt;
            int   rcnt;
            logic lrun;
            logic rrun;
            if (k == 0)          d = 0;
            else if (k % 2 == 1) d = -((k + 1) / 2);
            else                 d = k / 2;
            lcnt = 0;
            rcnt = 0;
            lrun = 1'b1;
            rrun = 1'b1;
            for (int m = 1; m <= MAXW; m++) begin
                if (lrun && (m <= wlim) && act_win[D - 3 - d + m]) lcnt = m;
                else                                               lrun = 1'b0;
                if (rrun && (m <= wlim) && act_win[D - 3 - d - m]) rcnt = m;
                else                                               rrun = 1'b0;
            end
            if (!hit && ctr_win[D - 4 - d]) begin
                if ((d > 0) && (d <= lcnt)) begin
                    hit   = 1'b1;
                    sel_u = raw_u[D - d + lcnt];
                    sel_v = raw_v[D - d + lcnt];
                end else if ((d <= 0) && (-d <= rcnt)) begin
                    hit   = 1'b1;
                    sel_u = raw_u[D - d - rcnt];
                    sel_v = raw_v[D - d - rcnt];
                end
            end
        end
    end

    // Register the decided pixel and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_u     <= '0;
            out_v     <= '0;
        end else begin
            out_valid <= adv;
            if (adv) begin
                out_u <= sel_u;
                out_v <= sel_v;
            end
        end
    end

endmodule

// File: rtl/chroma_edge_sharpener.sv
// Top level: two per-component front ends, a shared detector and the
// output selector. All state advances only on accepted pixels.
// Assumes: thresh and width are held steady during a stream.
module chroma_edge_sharpener #(
    parameter int DW   = chroma_sharp_pkg::CS_DATA_W,
    parameter int MAXW = chroma_sharp_pkg::CS_MAX_REACH,
    parameter int TW   = DW + 2,
    parameter int WW   = chroma_sharp_pkg::cs_reach_bits(MAXW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_u,
    input  logic [DW-1:0]  in_v,
    input  logic [TW-1:0]  thresh,
    input  logic [WW-1:0]  width,
    output logic           out_valid,
    output logic [DW-1:0]  out_u,
    output logic [DW-1:0]  out_v
);
    localparam int D    = chroma_sharp_pkg::cs_decide_delay(MAXW);
    localparam int RLEN = D + 2 * MAXW + 1;
    localparam int FLEN = D - 3 + 2 * MAXW + 1;
    localparam int CLEN = D - 4 + MAXW + 1;

    logic [1:0][DW-1:0]             comp_in;
    logic [RLEN-1:0][DW-1:0]        comp_taps [2];
    logic signed [DW:0]             comp_d1   [2];
    logic signed [DW+1:0]           comp_d2   [2];
    logic [FLEN-1:0]                act_win;
    logic [CLEN-1:0]                ctr_win;

    assign comp_in = {in_v, in_u};

    // One front end per chroma component.
    for (genvar c = 0; c < 2; c++) begin : g_comp
        cs_feature #(.DW(DW), .DEPTH(RLEN)) i_feature (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (in_valid),
            .din   (comp_in[c]),
            .taps  (comp_taps[c]),
            .d1    (comp_d1[c]),
            .d2    (comp_d2[c])
        );
    end

    cs_detect #(.DW(DW), .TW(TW), .FLEN(FLEN), .CLEN(CLEN)) i_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (in_valid),
        .d1u     (comp_d1[0]),
        .d2u     (comp_d2[0]),
        .d1v     (comp_d1[1]),
        .d2v     (comp_d2[1]),
        .thresh  (thresh),
        .act_win (act_win),
        .ctr_win (ctr_win)
    );

    cs_select #(.DW(DW), .MAXW(MAXW), .D(D), .RLEN(RLEN), .FLEN(FLEN),
                .CLEN(CLEN), .WW(WW)) i_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (in_valid),
        .width     (width),
        .raw_u     (comp_taps[0]),
        .raw_v     (comp_taps[1]),
        .act_win   (act_win),
        .ctr_win   (ctr_win),
        .out_valid (out_valid),
        .out_u     (out_u),
        .out_v     (out_v)
    );

endmodule

// File: rtl/chroma_edge_sharpener_chk.sv
// Protocol checks on the sharpener's ports: reset state, strobe timing
// and output hold across stalls.
// Assumes: bound to every chroma_edge_sharpener instance.
module chroma_edge_sharpener_chk #(
    parameter int DW = chroma_sharp_pkg::CS_DATA_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           out_valid,
    input logic [DW-1:0]  out_u,
    input logic [DW-1:0]  out_v
);
    logic was_in_reset = 1'b0;

    // R1: one cycle after a reset edge the outputs are cleared.
    always @(posedge clk) begin
        if (was_in_reset) begin
            a_r1_reset_clears: assert (!out_valid && out_u == '0 && out_v == '0)
                else $error("reset state not cleared");
        end
        was_in_reset <= !rst_n;
    end

    // R2: every accepted pixel yields a strobe on the next cycle.
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe without an accepted pixel one cycle earlier.
    a_r2_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: a stall cycle leaves the output samples untouched.
    a_r9_stall_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_u) && $stable(out_v)));

endmodule

bind chroma_edge_sharpener chroma_edge_sharpener_chk #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_u     (out_u),
    .out_v     (out_v)
);

// File: tb/test_chroma_edge_sharpener.sv
// Sweep bench: four stimulus patterns x five thresholds x four widths,
// with and without stall gaps, against an arithmetic model of the spec.
module test_chroma_edge_sharpener;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int MAXW = 3;
    localparam int DLY  = ((4 + MAXW) > (3 + 2 * MAXW)) ? (4 + MAXW) : (3 + 2 * MAXW);
    localparam int LAT  = DLY + 1;
    localparam int N    = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_u = '0, in_v = '0;
    logic [9:0]    thresh = '0;
    logic [1:0]    width = '0;
    logic          out_valid;
    logic [7:0]    out_u, out_v;

    int su [N];
    int sv [N];
    int cur_th, cur_tw;
    int n_cmp = 0, n_bad = 0;
    int ocount;
    logic mon_en = 1'b0;
    logic [7:0] last_u, last_v;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chroma_edge_sharpener i_chroma_edge_sharpener (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_u (in_u), .in_v (in_v), .thresh (thresh), .width (width),
        .out_valid (out_valid), .out_u (out_u), .out_v (out_v)
    );

    // ---- arithmetic model of the requirements ----
    function automatic int xs(input int c, input int i);
        if (i < 0 || i >= N) return 0;
        return (c == 0) ? su[i] : sv[i];
    endfunction
    function automatic int fs(input int c, input int i);     // R3
        return (xs(c, i - 1) + 2 * xs(c, i) + xs(c, i + 1) + 2) / 4;
    endfunction
    function automatic int g1(input int c, input int i);     // R4
        return fs(c, i + 1) - fs(c, i - 1);
    endfunction
    function automatic int g2(input int c, input int i);     // R4
        return fs(c, i + 1) - 2 * fs(c, i) + fs(c, i - 1);
    endfunction
    function automatic int iabs(input int a);
        return (a < 0) ? -a : a;
    endfunction
    function automatic int sgn(input int a);
        return (a > 0) ? 1 : ((a < 0) ? -1 : 0);
    endfunction
    function automatic bit actv(input int i);                // R4
        return (iabs(g1(0, i)) + iabs(g1(1, i))) > cur_th;
    endfunction
    function automatic int zc(input int i);                  // R5
        return sgn(g1(0, i)) * g2(0, i) + sgn(g1(1, i)) * g2(1, i);
    endfunction
    function automatic bit ctr(input int i);                 // R5
        return actv(i) && actv(i - 1) && (zc(i - 1) > 0) && (zc(i) <= 0);
    endfunction
    // Returns the source pixel index for output n; in_reg flags region membership (R6, R7, R8).
    function automatic int src_of(input int n, output bit in_reg);
        int w;
        w = (cur_tw > MAXW) ? MAXW : cur_tw;
        in_reg = 1'b0;
        for (int k = 0; k < 2 * MAXW + 1; k++) begin
            int d, c, l, r;
            d = (k == 0) ? 0 : ((k % 2 == 1) ? -((k + 1) / 2) : k / 2);
            c = n + d;
            if (ctr(c)) begin
                l = 0;
                while (l < w && actv(c - l - 1)) l++;
                r = 0;
                while (r < w && actv(c + r + 1)) r++;
                if (d > 0 && d <= l) begin in_reg = 1'b1; return c - l; end
                if (d <= 0 && -d <= r) begin in_reg = 1'b1; return c + r; end
            end
        end
        return n;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Output monitor: compares every strobed pixel, checks holds on gaps.
    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                int  n, s;
                bit  rg;
                string tag;
                n = ocount - LAT;                            // R2 alignment
                s = src_of(n, rg);
                if (cur_th >= 510)    tag = "R10 pass-through";
                else if (cur_tw == 0) tag = "R11 pass-through";
                else if (rg)          tag = "R3 R4 R5 R6 R7 region pixel";
                else                  tag = "R8 untouched pixel";
                check(tag, out_u, xs(0, s));
                check(tag, out_v, xs(1, s));
                last_u = out_u;
                last_v = out_v;
                ocount++;
            end else if (ocount > 0) begin
                check("R9 hold U on gap", out_u, last_u);
                check("R9 hold V on gap", out_v, last_v);
            end
        end
    end

    function automatic int pat(input int p, input int c, input int i);
        case (p)
            0: return (c == 0) ? ((i >= 20) ? 200 : 30) : ((i >= 35) ? 40 : 180);
            1: if (c == 0) return (i < 12) ? 10 : ((i < 20) ? 10 + (i - 12) * 25 : 210);
               else        return (i < 40) ? 128 : ((i < 44) ? 128 - (i - 40) * 20 : 48);
            2: return ((i * 37 + c * 91 + p * 13) ^ (i * i * 7 + c * 5)) & 255;
            default:
               if (c == 0) return (i >= 45) ? 90 : ((i < 25) ? 60 : ((i < 30) ? 60 + (i - 25) * 30 : 210));
               else        return (i >= 45) ? 170 : ((i < 25) ? 200 : ((i < 30) ? 200 - (i - 25) * 30 : 50));
        endcase
    endfunction

    task automatic run_case(input int p, input int th, input int tw, input bit gaps);
        for (int i = 0; i < N; i++) begin
            su[i] = pat(p, 0, i);
            sv[i] = pat(p, 1, i);
        end
        cur_th = th;
        cur_tw = tw;
        @(negedge clk);
        mon_en   = 1'b0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        thresh   = 10'(th);
        width    = 2'(tw);
        @(negedge clk);
        @(negedge clk);
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset out_u", out_u, 0);
        check("R1 reset out_v", out_v, 0);
        rst_n  = 1'b1;
        ocount = 0;
        mon_en = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (gaps && ((i * 3 + p) % 4 == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_u = 8'(su[i]);
            in_v = 8'(sv[i]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 one output per accepted pixel", ocount, N);
        mon_en = 1'b0;
    endtask

    initial begin
        int ths [5];
        ths = '{0, 12, 40, 100, 1023};
        for (int p = 0; p < 4; p++)
            for (int t = 0; t < 5; t++)
                for (int w = 0; w < 4; w++)
                    run_case(p, ths[t], w, ((p + t + w) % 2) == 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule